// File: doc/BRIEF.md
# Rotate-and-Mask Shift Unit

This block is the shift and rotate datapath of a 64-bit integer execution unit. Each accepted operation is built from the same three stages. A control decoder turns the operation select and the operand fields into four things: a rotate amount, a pair of mask bounds, a source word, and a choice of what fills the bits outside the mask. A logarithmic rotator and a mask generator then produce their parts, and a merge stage combines them. The result is registered, so it appears one clock after the operation is presented.

The block covers three groups of operations. The first is 32-bit rotates, with mask or with insert into a destination value. The second is 64-bit rotates that clear on the left, on the right, or on both sides. The third is logical shifts on 32 and 64 bits, an arithmetic right shift on 32 bits, and a shift left of the sign-extended low word.

Mask bounds use MSB-first numbering, in which bit 0 is the most significant. When the begin field is greater than the end field, the mask wraps around. Register-sourced shift amounts carry one extra high bit, and that bit forces an out-of-range result.

Top module: `rotmask_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and `result` are cleared to zero on that edge.
- R2: An operation presented with `in_valid` high produces its `result`, with `out_valid` high, exactly one clock later. `out_valid` is low in every cycle that does not follow an accepted operation.
- R3: The `op` encoding is: 0 word rotate-and-mask, 1 word rotate-and-insert, 2 doubleword rotate clear-left, 3 doubleword rotate clear-right, 4 doubleword rotate clear-both, 5 word shift left, 6 word shift right logical, 7 word shift right arithmetic, 8 doubleword shift left, 9 doubleword shift right logical, 10 sign-extend word then shift left. Codes 11 to 15 give a zero result.
- R4: Word rotate-and-mask works as follows. The low 32 bits of `rs` are rotated left by `sh[4:0]`, and the rotated word is placed in both halves. The word is then ANDed with a mask that covers MSB-first bits `mb[4:0]+32` through `me[4:0]+32`. Bits `sh[6:5]`, `mb[5]` and `me[5]` are ignored.
- R5: Word rotate-and-insert uses the same rotation and mask as R4. Mask bits take the rotated value, and all other bits take `ra`.
- R6: The mask covers the inclusive MSB-first range from begin to end. If begin is greater than end, the mask covers every bit except end+1 through begin-1, and for word rotates this also sets the whole upper half.
- R7: All three doubleword rotates rotate `rs` left by `sh[5:0]`. Clear-left keeps MSB-first bits `mb` to 63. Clear-right keeps bits 0 to `me`. Clear-both keeps bits `mb` to 63-`sh[5:0]`.
- R8: Word logical shifts use `sh[5:0]`. The low word is shifted, and the upper 32 bits of the result are zero. If `sh[5]` is 1, the result is zero. `sh[6]` is ignored.
- R9: For the word arithmetic right shift, the result is the low word, sign-extended to 64 bits, shifted right arithmetically by `sh[4:0]`. If `sh[5]` is 1, every result bit equals `rs[31]`.
- R10: Doubleword logical shifts use `sh[6:0]`. A shift of 0 returns `rs` unchanged, and any amount of 64 or more gives zero.
- R11: Sign-extend-then-shift replaces the upper 32 bits of `rs` with copies of `rs[31]`, then shifts left by `sh[5:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation presented this cycle |
| op | input | 4 | Operation select (encoding in R3) |
| rs | input | 64 | Source operand |
| ra | input | 64 | Destination value merged by the insert operation |
| sh | input | 7 | Shift or rotate amount; bit 6 is the out-of-range bit of doubleword register shifts |
| mb | input | 6 | Mask begin field, MSB-first |
| me | input | 6 | Mask end field, MSB-first |
| out_valid | output | 1 | `result` holds the outcome of the previous cycle's operation |
| result | output | 64 | Registered result |

## Verification
The assertions assume a few things about the inputs. They assume `op` holds one of the defined codes whenever `in_valid` is high. They assume the fields an operation ignores may hold any value. They assume `mb` and `me` are compared only in their used low bits, so the word-mask property does not depend on bit 5.

The stimulus stays within these assumptions. It drives every defined code, and it drives one undefined code only for the zero-result check. It deliberately sets the ignored high bits of `sh` on some word operations.

Shift amounts cover the whole range from 0 to 127. This range includes the boundaries at 31, 32, 63 and 64. Mask fields are chosen to give both a wrapping range and a non-wrapping range.

// File: rtl/rmu_pkg.sv
package rmu_pkg;

  typedef enum logic [3:0] {
    OP_RLW_MASK = 4'd0,
    OP_RLW_INS  = 4'd1,
    OP_RLD_CL   = 4'd2,
    OP_RLD_CR   = 4'd3,
    OP_RLD_CB   = 4'd4,
    OP_SLW      = 4'd5,
    OP_SRW      = 4'd6,
    OP_SRAW     = 4'd7,
    OP_SLD      = 4'd8,
    OP_SRD      = 4'd9,
    OP_EXT_SL   = 4'd10
  } rmu_op_e;

  // how bits outside the mask are filled
  typedef enum logic [1:0] {
    FILL_ZERO = 2'd0,
    FILL_SIGN = 2'd1,
    FILL_DEST = 2'd2
  } rmu_fill_e;

endpackage

// File: rtl/rmu_ctrl.sv
module rmu_ctrl
  import rmu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [3:0]               op,
  input  logic [XLEN-1:0]          rs,
  input  logic [$clog2(XLEN):0]    sh,
  input  logic [$clog2(XLEN)-1:0]  mb,
  input  logic [$clog2(XLEN)-1:0]  me,
  output logic [XLEN-1:0]          src,
  output logic [$clog2(XLEN)-1:0]  rot,
  output logic [$clog2(XLEN)-1:0]  mask_b,
  output logic [$clog2(XLEN)-1:0]  mask_e,
  output logic                     kill,
  output rmu_fill_e                fill,
  output logic                     sign_bit
);
  localparam int LG   = $clog2(XLEN);
  localparam int HALF = XLEN / 2;
  localparam int HLG  = LG - 1;

  logic [HALF-1:0]  lo_word;
  logic [XLEN-1:0]  dup_word;
  logic [XLEN-1:0]  sext_word;
  logic [HLG-1:0]   sh_w;
  logic [LG-1:0]    sh_d;
  rmu_op_e          op_e;

  assign op_e      = rmu_op_e'(op);
  assign lo_word   = rs[HALF-1:0];
  assign dup_word  = {lo_word, lo_word};
  assign sext_word = {{HALF{lo_word[HALF-1]}}, lo_word};
  assign sh_w      = sh[HLG-1:0];
  assign sh_d      = sh[LG-1:0];
  assign sign_bit  = lo_word[HALF-1];

  always_comb begin
    src    = rs;
    rot    = sh_d;
    mask_b = '0;
    mask_e = '1;
    kill   = 1'b0;
    fill   = FILL_ZERO;
    unique case (op_e)
      OP_RLW_MASK, OP_RLW_INS: begin
        src    = dup_word;
        rot    = {1'b0, sh_w};
        mask_b = {1'b1, mb[HLG-1:0]};
        mask_e = {1'b1, me[HLG-1:0]};
        if (op_e == OP_RLW_INS) fill = FILL_DEST;
      end
      OP_RLD_CL: mask_b = mb;
      OP_RLD_CR: mask_e = me;
      OP_RLD_CB: begin
        mask_b = mb;
        mask_e = ~sh_d;
      end
      OP_SLW: begin
        src    = dup_word;
        rot    = {1'b0, sh_w};
        mask_b = {1'b1, {HLG{1'b0}}};
        mask_e = {1'b1, ~sh_w};
        kill   = sh[HLG];
      end
      OP_SRW, OP_SRAW: begin
        src    = dup_word;
        rot    = {1'b0, HLG'(-sh_w)};
        mask_b = {1'b1, sh_w};
        kill   = sh[HLG];
        if (op_e == OP_SRAW) fill = FILL_SIGN;
      end
      OP_SLD: begin
        mask_e = ~sh_d;
        kill   = sh[LG];
      end
      OP_SRD: begin
        rot    = LG'(-sh_d);
        mask_b = sh_d;
        kill   = sh[LG];
      end
      OP_EXT_SL: begin
        src    = sext_word;
        mask_e = ~sh_d;
      end
      default: begin
        src  = '0;
        kill = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/rmu_rotl.sv
module rmu_rotl #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]         din,
  input  logic [$clog2(XLEN)-1:0] amt,
  output logic [XLEN-1:0]         dout
);
  localparam int LG = $clog2(XLEN);

  logic [XLEN-1:0] stg [0:LG];
  assign stg[0] = din;

  for (genvar s = 0; s < LG; s++) begin : g_stage
    localparam int D = 1 << s;
    assign stg[s+1] = amt[s] ? {stg[s][XLEN-1-D:0], stg[s][XLEN-1:XLEN-D]}
                             : stg[s];
  end

  assign dout = stg[LG];

  // R4 rotation neither creates nor drops set bits
  always_comb begin
    rot_ones_chk: assert ($countones(dout) == $countones(din))
      else $error("rotator changed bit population");
  end

endmodule

// File: rtl/rmu_mask.sv
module rmu_mask #(
  parameter int XLEN = 64
) (
  input  logic [$clog2(XLEN)-1:0] b,
  input  logic [$clog2(XLEN)-1:0] e,
  output logic [XLEN-1:0]         mask
);
  localparam int LG = $clog2(XLEN);

  logic wrap;
  assign wrap = b > e;

  for (genvar k = 0; k < XLEN; k++) begin : g_bit
    localparam logic [LG-1:0] POS = LG'(XLEN - 1 - k);
    logic above_b, below_e;
    assign above_b = POS >= b;
    assign below_e = POS <= e;
    assign mask[k] = wrap ? (above_b | below_e) : (above_b & below_e);
  end

  // R6 population of the mask matches the inclusive (possibly wrapped) range
  always_comb begin
    mask_span_chk: assert ($countones(mask) ==
        (wrap ? (XLEN - int'(b) + int'(e) + 1) : (int'(e) - int'(b) + 1)))
      else $error("mask population mismatch");
  end

endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
  import rmu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [3:0]              op,
  input  logic [XLEN-1:0]         rs,
  input  logic [XLEN-1:0]         ra,
  input  logic [$clog2(XLEN):0]   sh,
  input  logic [$clog2(XLEN)-1:0] mb,
  input  logic [$clog2(XLEN)-1:0] me,
  output logic                    out_valid,
  output logic [XLEN-1:0]         result
);
  localparam int LG   = $clog2(XLEN);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] src, rotated, mask, mask_eff, outside, merged;
  logic [LG-1:0]   rot, mask_b, mask_e;
  logic            kill, sign_bit;
  rmu_fill_e       fill;

  rmu_ctrl #(.XLEN(XLEN)) u_ctrl (
    .op(op), .rs(rs), .sh(sh), .mb(mb), .me(me),
    .src(src), .rot(rot), .mask_b(mask_b), .mask_e(mask_e),
    .kill(kill), .fill(fill), .sign_bit(sign_bit)
  );

  rmu_rotl #(.XLEN(XLEN)) u_rotl (
    .din(src), .amt(rot), .dout(rotated)
  );

  rmu_mask #(.XLEN(XLEN)) u_mask (
    .b(mask_b), .e(mask_e), .mask(mask)
  );

  assign mask_eff = kill ? '0 : mask;

  always_comb begin
    unique case (fill)
      FILL_SIGN: outside = {XLEN{sign_bit}};
      FILL_DEST: outside = ra;
      default:   outside = '0;
    endcase
  end

  assign merged = (rotated & mask_eff) | (outside & ~mask_eff);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= merged;
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R10
  dw_range_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == OP_SLD || op == OP_SRD) && sh[LG]) |=> (result == '0));

  // R9
  sraw_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_SRAW) |=> (result[XLEN-1:HALF] == {HALF{$past(rs[HALF-1])}}));

  // R4
  word_upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_RLW_MASK && mb[LG-2:0] <= me[LG-2:0])
      |=> (result[XLEN-1:HALF] == '0));

  // R8
  word_shift_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == OP_SLW || op == OP_SRW)) |=> (result[XLEN-1:HALF] == '0));

endmodule

// File: tb/test_rotmask_unit.sv
module test_rotmask_unit;
  import rmu_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [63:0] rs = '0, ra = '0;
  logic [6:0]  sh = '0;
  logic [5:0]  mb = '0, me = '0;
  logic        out_valid;
  logic [63:0] result;

  int checks = 0;
  int fails  = 0;
  logic [63:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  rotmask_unit i_rotmask_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .rs(rs), .ra(ra),
    .sh(sh), .mb(mb), .me(me), .out_valid(out_valid), .result(result)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] o, input logic [63:0] a_rs, input logic [63:0] a_ra,
                      input logic [6:0] a_sh, input logic [5:0] a_mb, input logic [5:0] a_me,
                      input logic [63:0] exp, input string tag);
    @(negedge clk);
    op = o; rs = a_rs; ra = a_ra; sh = a_sh; mb = a_mb; me = a_me;
    in_valid = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // shift model written from the requirements with plain operators
  function automatic logic [63:0] shift_model(input logic [3:0] o, input logic [63:0] x,
                                              input logic [6:0] s);
    logic [63:0] sx;
    sx = {{32{x[31]}}, x[31:0]};
    case (o)
      OP_SLW:    return s[5] ? 64'd0 : {32'd0, x[31:0] << s[4:0]};
      OP_SRW:    return s[5] ? 64'd0 : {32'd0, x[31:0] >> s[4:0]};
      OP_SRAW:   return $signed(sx) >>> (s[5] ? 6'd63 : {1'b0, s[4:0]});
      OP_SLD:    return s[6] ? 64'd0 : x << s[5:0];
      OP_SRD:    return s[6] ? 64'd0 : x >> s[5:0];
      OP_EXT_SL: return sx << s[5:0];
      default:   return 64'd0;
    endcase
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected out_valid", {63'd0, out_valid}, 64'd0);
      end else begin
        check(tag_q.pop_front(), result, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 10);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset out_valid", {63'd0, out_valid}, 64'd0);
    check("R1 reset result", result, 64'd0);
    @(negedge clk) rst = 1'b0;

    // R4 word rotate-and-mask
    send(OP_RLW_MASK, 64'h8fffffff, 0, 7'd1, 6'd31, 6'd31, 64'h1, "R4 sign extract");
    send(OP_RLW_MASK, 64'hebeb1888, 0, 7'd0, 6'd16, 6'd31, 64'h1888, "R4 clear upper");
    send(OP_RLW_MASK, 64'hf1110001, 0, 7'd1, 6'd0, 6'd30, 64'he2220002, "R4 rotate one");
    send(OP_RLW_MASK, 64'hfebaacda, 0, 7'd16, 6'd8, 6'd11, 64'hd00000, "R4 narrow field");
    send(OP_RLW_MASK, 64'h111, 0, 7'h61, 6'd0, 6'd31, 64'h222, "R4 high sh bits ignored");
    send(OP_RLW_MASK, 64'h12345678, 0, 7'd0, 6'd56, 6'd39, 64'h1234567812000078,
         "R6 wrapped word mask");
    // R5 insert
    send(OP_RLW_INS, 64'hcc, 64'h7f00ffff, 7'd16, 6'd8, 6'd15, 64'h7fccffff, "R5 insert byte");
    send(OP_RLW_INS, 64'h1, 64'h7fffffff, 7'd31, 6'd0, 6'd0, 64'hffffffff, "R5 insert msb");
    // R7 doubleword rotates
    send(OP_RLD_CL, 64'h1000dead0000111c, 0, 7'd32, 6'd47, 6'd0, 64'hdead, "R7 clear left");
    send(OP_RLD_CL, 64'h0100ffff00000111, 0, 7'd8, 6'd44, 6'd0, 64'h11101, "R7 clear left 8");
    send(OP_RLD_CR, 64'h0100ffffe0000111, 0, 7'd16, 6'd0, 6'd15, 64'hffff000000000000,
         "R7 clear right");
    send(OP_RLD_CR, 64'h1000caef0000dead, 0, 7'd32, 6'd0, 6'd32, 64'hdead00000000,
         "R7 clear right 32");
    send(OP_RLD_CB, 64'h0100ffff00000111, 0, 7'd8, 6'd31, 6'd0, 64'h11100, "R7 clear both");
    send(OP_RLD_CB, 64'h0100ffff00000fff, 0, 7'd0, 6'd51, 6'd0, 64'hfff, "R7 clear both no rot");
    // R10 / R9 / R11 named corners
    send(OP_SLD, 64'hffffffffffffffff, 0, 7'd64, 0, 0, 64'h0, "R10 shift by 64");
    send(OP_SLD, 64'h8000000000000000, 0, 7'd0, 0, 0, 64'h8000000000000000, "R10 shift by 0");
    send(OP_SRAW, 64'h82345678, 0, 7'd8, 0, 0, 64'hffffffffff823456, "R9 negative");
    send(OP_SRAW, 64'h12345678, 0, 7'd8, 0, 0, 64'h123456, "R9 positive");
    send(OP_SRAW, 64'h80000000, 0, 7'd32, 0, 0, 64'hffffffffffffffff, "R9 out of range");
    send(OP_SLW, 64'h1, 0, 7'h41, 0, 0, 64'h2, "R8 sh bit6 ignored");
    send(OP_SLW, 64'hffffffffffffffff, 0, 7'd32, 0, 0, 64'h0, "R8 out of range");
    send(OP_EXT_SL, 64'h0000010180122900, 0, 7'd0, 0, 0, 64'hffffffff80122900, "R11 sext");
    send(OP_EXT_SL, 64'h5678, 0, 7'd31, 0, 0, 64'h2b3c00000000, "R11 shift 31");
    send(OP_EXT_SL, 64'h3ffffd7377f19fdd, 0, 7'd7, 0, 0, 64'h3bf8cfee80, "R11 shift 7");
    send(4'd13, 64'hffffffffffffffff, 64'hffffffffffffffff, 7'd3, 6'd0, 6'd63, 64'h0,
         "R3 unused code");

    // R8 R9 R10 R11 sweep against the shift model
    for (int p = 0; p < 4; p++) begin
      logic [63:0] pat;
      pat = (p == 0) ? 64'hfedcba9876543210 : (p == 1) ? 64'h00000000ffffffff :
            (p == 2) ? 64'h123456787fffffff : 64'h8000000180000001;
      for (int s = 0; s < 128; s += 7) begin
        for (int k = 5; k <= 10; k++) begin
          send(4'(k), pat, 64'h0, 7'(s), 6'(s), 6'(~s),
               shift_model(4'(k), pat, 7'(s)), "R8 R9 R10 R11 sweep");
        end
      end
    end

    @(negedge clk) in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 idle out_valid", {63'd0, out_valid}, 64'd0);
    check("R2 all results seen", 64'(exp_q.size()), 64'd0);

    // R1 reset mid-stream
    send(OP_SLD, 64'h1, 0, 7'd1, 0, 0, 64'h2, "R2 before reset");
    @(negedge clk) begin in_valid = 1'b0; rst = 1'b1; end
    @(negedge clk);
    check("R1 reset clears result", result, 64'd0);
    check("R1 reset clears valid", {63'd0, out_valid}, 64'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule